// File: doc/BRIEF.md
# Frame-Referenced Nibble Bit-Slip Aligner

This block sits behind a 4-bit deserializer on a link that carries one frame lane and several data lanes. While the converter sends its sync pattern, the block first shifts the frame lane's 4-bit extraction window until the frame nibbles follow the expected three-nibble rotation. It then shifts each data lane's window separately, keeping within one bit of the frame's window, until the lane's nibbles equal the sync nibbles that belong to the frame phase seen in the same cycle.

A `start` pulse begins a search. The block then reports lock per lane and for the whole link. If no window can be found for the frame lane, or for any data lane, it reports failure and emits a one-cycle request for input delay recalibration. Lock and failure remain set until the next `start` or reset. The aligned nibbles are driven continuously from the selected windows.

Top module: `nibble_slip_align`

## Requirements
- R1: After reset, `frame_lock`, `lane_lock`, `data_lock`, `fail` and `recal_req` are low, and `frame_aligned` reads 0000.
- R2: Each lane keeps an 8-bit history. A new raw nibble enters it each cycle, with the older nibble in the upper half and the first bit of each nibble at the MSB. Window offset s selects the four bits starting s positions below bit 7. The frame search tries offsets 1, 2 and 3 in that order. It declares frame lock after LOCK_CNT consecutive tested nibbles that are each one of 1110, 0011 or 1000, with each following the previous one in the cycle 1110 -> 0011 -> 1000 -> 1110.
- R3: While `frame_lock` is high on a steady frame stream, `frame_aligned` shows only 1110, 0011 and 1000, in that cyclic order.
- R4: The data-lane search starts only after frame lock. With the frame at offset f, each lane tries offset f, then f-1, then f+1. A lane locks after LOCK_CNT consecutive tested cycles in which its window equals the expected nibble. The expected nibble is bits [11:8] of P={SYNC,SYNC} when the frame shows 1110, bits [7:4] when it shows 0011, and bits [3:0] when it shows 1000. `data_lock` is high when every lane is locked and `fail` is low.
- R5: A data lane whose bit skew differs from the frame's by -1, 0 or +1 bit locks, and its aligned nibble then always equals the expected nibble of R4.
- R6: If all three frame offsets fail, or any lane fails all three of its offsets, `fail` rises. In the same cycle `recal_req` is high for exactly one cycle, and `data_lock` stays low.
- R7: `frame_lock`, `lane_lock` and `fail` hold until `start` or reset. A `start` clears them at the next edge and restarts the frame search.
- R8: After every offset change, and after the search begins, the block waits SETTLE cycles before it tests a nibble. So a constant frame input fails exactly 3*(SETTLE+1) edges after the start edge. A lane with zero skew relative to the frame locks exactly SETTLE+LOCK_CNT edges after the frame locks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new alignment search |
| frame_nib | input | 4 | Raw frame-lane nibble |
| data_nib | input | LANES*4 | Raw data-lane nibbles, lane i at bits [4i+3:4i] |
| frame_aligned | output | 4 | Frame nibble from the selected window |
| data_aligned | output | LANES*4 | Data nibbles from each lane's selected window |
| frame_lock | output | 1 | Frame alignment found |
| lane_lock | output | LANES | Per-lane alignment found |
| data_lock | output | 1 | All lanes locked, no failure |
| fail | output | 1 | Alignment search failed |
| recal_req | output | 1 | One-cycle request for delay recalibration |

## Verification
The hardest situations to reach are a data lane that locks only on its third candidate offset, and a lane whose skew lies just outside the one-bit margin. In both cases the frame has already locked, at an offset the bench does not choose. The bench therefore generates the bit streams arithmetically. It sweeps the frame skew over the whole six-bit frame period and each lane's relative skew over -1, 0 and +1, so that every candidate order is reached from every frame offset. A relative skew of +2 is then used to force the exhaustion path.

// File: rtl/nibble_slip_align.sv
module nibble_slip_align #(
  parameter int LANES = 2,
  parameter int LOCK_CNT = 6,
  parameter int SETTLE = 3,
  parameter logic [5:0] SYNC = 6'b110100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [3:0]         frame_nib,
  input  logic [LANES*4-1:0] data_nib,
  output logic [3:0]         frame_aligned,
  output logic [LANES*4-1:0] data_aligned,
  output logic               frame_lock,
  output logic [LANES-1:0]   lane_lock,
  output logic               data_lock,
  output logic               fail,
  output logic               recal_req
);
  localparam int CW = $clog2(LOCK_CNT + SETTLE + 1) + 1;
  localparam logic [11:0] PAT = {SYNC, SYNC};
  localparam logic [CW-1:0] RUN_LAST = CW'(LOCK_CNT - 1);
  localparam logic [CW-1:0] WAIT_INIT = CW'(SETTLE);

  typedef enum logic [2:0] {S_IDLE, S_FRAME, S_DATA, S_DONE, S_FAIL} st_t;

  function automatic logic [3:0] win(input logic [7:0] h, input logic [2:0] s);
    logic [7:0] t;
    t = h >> (3'd4 - s);
    return t[3:0];
  endfunction

  function automatic logic [3:0] succ(input logic [3:0] v);
    case (v)
      4'b1110: return 4'b0011;
      4'b0011: return 4'b1000;
      default: return 4'b1110;
    endcase
  endfunction

  function automatic logic [3:0] expn(input logic [3:0] v);
    case (v)
      4'b1110: return PAT[11:8];
      4'b0011: return PAT[7:4];
      default: return PAT[3:0];
    endcase
  endfunction

  st_t             state;
  logic [7:0]      fhist;
  logic [2:0]      fslip;
  logic [CW-1:0]   fwait, frun;
  logic [3:0]      fprev;
  logic [LANES-1:0] lane_bad;
  logic            fvalid, fok, go_data;

  assign frame_aligned = win(fhist, fslip);
  assign fvalid = (frame_aligned == 4'b1110) || (frame_aligned == 4'b0011) ||
                  (frame_aligned == 4'b1000);
  assign fok = fvalid && (frun == '0 || frame_aligned == succ(fprev));
  assign go_data = (state == S_FRAME) && (fwait == '0) && fok && (frun == RUN_LAST);
  assign fail = (state == S_FAIL);
  assign data_lock = (&lane_lock) && !fail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fhist <= '0;
      state <= S_IDLE;
      fslip <= 3'd1;
      fwait <= '0;
      frun <= '0;
      fprev <= '0;
      frame_lock <= 1'b0;
      recal_req <= 1'b0;
    end else begin
      fhist <= {fhist[3:0], frame_nib};
      recal_req <= 1'b0;
      if (start) begin
        state <= S_FRAME;
        fslip <= 3'd1;
        fwait <= WAIT_INIT;
        frun <= '0;
        frame_lock <= 1'b0;
      end else begin
        case (state)
          S_FRAME: begin
            if (fwait != '0) begin
              fwait <= fwait - 1'b1;
            end else if (fok) begin
              fprev <= frame_aligned;
              frun <= frun + 1'b1;
              if (frun == RUN_LAST) begin
                frame_lock <= 1'b1;
                state <= S_DATA;
              end
            end else begin
              frun <= '0;
              if (fslip == 3'd3) begin
                state <= S_FAIL;
                recal_req <= 1'b1;
              end else begin
                fslip <= fslip + 3'd1;
                fwait <= WAIT_INIT;
              end
            end
          end
          S_DATA: begin
            if (|lane_bad) begin
              state <= S_FAIL;
              recal_req <= 1'b1;
            end else if (&lane_lock) begin
              state <= S_DONE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [7:0]    dhist;
    logic [2:0]    lslip;
    logic [1:0]    ltry;
    logic [CW-1:0] lwait, lrun;
    logic [3:0]    dwin;

    assign dwin = win(dhist, lslip);
    assign data_aligned[i*4 +: 4] = dwin;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dhist <= '0;
        lslip <= 3'd1;
        ltry <= '0;
        lwait <= '0;
        lrun <= '0;
        lane_lock[i] <= 1'b0;
        lane_bad[i] <= 1'b0;
      end else begin
        dhist <= {dhist[3:0], data_nib[i*4 +: 4]};
        if (start) begin
          lane_lock[i] <= 1'b0;
          lane_bad[i] <= 1'b0;
          ltry <= '0;
          lrun <= '0;
        end else if (go_data) begin
          lslip <= fslip;
          ltry <= '0;
          lwait <= WAIT_INIT;
          lrun <= '0;
        end else if (state == S_DATA && !lane_lock[i] && !lane_bad[i]) begin
          if (lwait != '0) begin
            lwait <= lwait - 1'b1;
          end else if (dwin == expn(frame_aligned)) begin
            lrun <= lrun + 1'b1;
            if (lrun == RUN_LAST) lane_lock[i] <= 1'b1;
          end else begin
            lrun <= '0;
            if (ltry == 2'd2) begin
              lane_bad[i] <= 1'b1;
            end else begin
              lslip <= (ltry == 2'd0) ? fslip - 3'd1 : fslip + 3'd1;
              ltry <= ltry + 2'd1;
              lwait <= WAIT_INIT;
            end
          end
        end
      end
    end
  end
endmodule

module nibble_slip_align_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic frame_lock,
  input logic data_lock,
  input logic fail,
  input logic recal_req
);
  a_r4_data_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
    data_lock |-> frame_lock);
  a_r6_recal_on_fail_entry: assert property (@(posedge clk) disable iff (!rst_n)
    recal_req |-> fail && !$past(fail));
  a_r6_recal_single: assert property (@(posedge clk) disable iff (!rst_n)
    recal_req |=> !recal_req);
  a_r6_fail_blocks_lock: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> !data_lock);
  a_r7_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    frame_lock && !start |=> frame_lock);
  a_r7_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fail && !start |=> fail);
  a_r7_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !frame_lock && !fail);
endmodule

bind nibble_slip_align nibble_slip_align_chk u_chk (.*);

// File: tb/nibble_slip_align_test.sv
module nibble_slip_align_test;
  localparam int CLK_P = 10;
  localparam int LANES = 2;
  localparam int LOCK_CNT = 6;
  localparam int SETTLE = 3;
  localparam logic [5:0] S6 = 6'b110100;
  localparam logic [11:0] P = {S6, S6};

  logic clk = 0, rst_n = 0, start = 0;
  logic [3:0] frame_nib, frame_aligned;
  logic [LANES*4-1:0] data_nib, data_aligned;
  logic frame_lock, data_lock, fail, recal_req;
  logic [LANES-1:0] lane_lock;

  int cyc = 0, fsk = 0, dsk0 = 0, dsk1 = 0;
  bit fgarb = 0;
  int n_chk = 0, n_bad = 0;

  nibble_slip_align #(.LANES(LANES), .LOCK_CNT(LOCK_CNT), .SETTLE(SETTLE), .SYNC(S6)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_nib(frame_nib), .data_nib(data_nib),
    .frame_aligned(frame_aligned), .data_aligned(data_aligned), .frame_lock(frame_lock),
    .lane_lock(lane_lock), .data_lock(data_lock), .fail(fail), .recal_req(recal_req));

  always #(CLK_P/2) clk = ~clk;
  always @(negedge clk) cyc <= cyc + 1;

  function automatic logic [3:0] nib(int c, int sk, bit is_frame);
    logic [3:0] r;
    for (int j = 0; j < 4; j++) begin
      int p;
      p = (((4*c + j - sk) % 6) + 6) % 6;
      r[3-j] = is_frame ? (p < 3) : S6[5-p];
    end
    return r;
  endfunction

  function automatic logic [3:0] expd(logic [3:0] fv);
    if (fv == 4'b1110) return P[11:8];
    if (fv == 4'b0011) return P[7:4];
    return P[3:0];
  endfunction

  function automatic logic [3:0] nxt(logic [3:0] fv);
    if (fv == 4'b1110) return 4'b0011;
    if (fv == 4'b0011) return 4'b1000;
    return 4'b1110;
  endfunction

  assign frame_nib = fgarb ? 4'b0000 : nib(cyc, fsk, 1'b1);
  assign data_nib = {nib(cyc, dsk1, 1'b0), nib(cyc, dsk0, 1'b0)};

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(output int fl, output int dl, output int fk, output int rc);
    fl = -1; dl = -1; fk = -1; rc = 0;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    chk(!frame_lock && !fail, "R7 start clears", int'(frame_lock) + int'(fail), 0);
    for (int k = 0; k < 300; k++) begin
      if (frame_lock && fl < 0) fl = k;
      if (data_lock && dl < 0) dl = k;
      if (fail && fk < 0) fk = k;
      if (recal_req) rc++;
      if (dl >= 0 || (fk >= 0 && k >= fk + 5)) break;
      @(negedge clk);
    end
  endtask

  int fl, dl, fk, rc;

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!frame_lock && lane_lock == 0 && !data_lock && !fail && !recal_req, "R1 flags",
        int'(frame_lock) + int'(fail) + int'(data_lock) + int'(recal_req), 0);
    chk(frame_aligned == 4'b0000, "R1 frame_aligned", frame_aligned, 0);
    rst_n = 1;

    for (int f = 0; f < 6; f++)
      for (int a = -1; a <= 1; a++)
        for (int b = -1; b <= 1; b++) begin
          bit okf, okd;
          logic [3:0] pv;
          fsk = f; dsk0 = f + a; dsk1 = f + b;
          run(fl, dl, fk, rc);
          chk(dl >= 0 && fk < 0, "R5 lock within one bit", dl, 1);
          chk(fl >= SETTLE + LOCK_CNT, "R2 lock needs settle and run", fl, SETTLE + LOCK_CNT);
          if (a == 0 && b == 0)
            chk(dl == fl + SETTLE + LOCK_CNT, "R8 zero-skew lane timing", dl - fl, SETTLE + LOCK_CNT);
          okf = 1; okd = 1; pv = frame_aligned;
          for (int t = 0; t < 12; t++) begin
            @(negedge clk);
            if (!(frame_aligned == nxt(pv))) okf = 0;
            if (data_aligned[3:0] != expd(frame_aligned) ||
                data_aligned[7:4] != expd(frame_aligned)) okd = 0;
            pv = frame_aligned;
          end
          chk(okf, "R3 frame cycle", frame_aligned, nxt(pv));
          chk(okd, "R5 R4 lane data", data_aligned, {expd(frame_aligned), expd(frame_aligned)});
        end

    repeat (30) @(negedge clk);
    chk(frame_lock && data_lock && lane_lock == 2'b11, "R7 lock sticky", lane_lock, 3);

    fsk = 1; dsk0 = 1; dsk1 = 3;
    run(fl, dl, fk, rc);
    chk(fk >= 0 && dl < 0, "R6 lane skew two fails", fk, 1);
    chk(frame_lock && lane_lock[0] && !lane_lock[1], "R6 lane lock pattern", lane_lock, 1);
    chk(rc == 1, "R6 recal pulse count", rc, 1);
    repeat (20) @(negedge clk);
    chk(fail && !data_lock, "R7 fail sticky", fail, 1);

    fsk = 4; dsk0 = 1; dsk1 = 4;
    run(fl, dl, fk, rc);
    chk(fk >= 0 && !lane_lock[0], "R6 lane skew minus three fails", fk, 1);

    fgarb = 1;
    run(fl, dl, fk, rc);
    chk(fk == 3 * (SETTLE + 1), "R8 R6 frame fail timing", fk, 3 * (SETTLE + 1));
    chk(fl < 0 && !frame_lock, "R6 no frame lock", fl, -1);
    chk(rc == 1, "R6 recal on frame fail", rc, 1);

    fgarb = 0; fsk = 2; dsk0 = 2; dsk1 = 2;
    run(fl, dl, fk, rc);
    chk(dl >= 0 && !fail, "R7 restart after fail", dl, 1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule